// File: doc/BRIEF.md
# Fall-Through Shift-Handshake FIFO

A first-in first-out buffer of 64 words of 9 bits. A writer and a reader each move words with a two-wire shift handshake. On the write side the writer raises `si` while `dir` is high to hand over the word on `din`. On the read side the reader raises `so` while `dor` is high to take the word shown on `dout`.

Inside the block, words do not sit at fixed addresses. Each word falls through a chain of stages from the input stage toward the output stage. It advances one stage per clock whenever the next stage is free. Words therefore pack together at the output end and the free stages gather at the input end. Each control input has a rising phase and a falling phase, and the two phases do different jobs. The rise takes or gives up a word. The fall releases the input stage, or lets the output stage refill.

Back-pressure works through the two flags. A low `dir` means the input stage is busy or the buffer is full, and a writer that keeps `si` high simply waits. A low `dor` means no word is ready, and a reader that raises `so` while the buffer is wholly empty is served automatically by the next arriving word. The writer and reader may also pulse `si` and `so` blindly in bursts, provided no more words are sent than the buffer can store.

Top module: `shift_fifo`

## Requirements
- R1: While `mrst_n` is low, all stages are cleared. After reset, `dir` is 1, `dor` is 0 and `dout` is 0.
- R2: A rising `si` sampled while `dir` is 1 stores `din` in the input stage, and `dir` reads 0 from the next cycle.
- R3: While `si` stays high after a capture, the word stays in the input stage and `dir` stays 0.
- R4: Once `si` is sampled low, the word leaves the input stage. `dir` returns to 1 if any stage is free. With 64 words stored, `dir` stays 0 and `dor` is 1.
- R5: If `si` is raised while the buffer is full and then held high, a later shift-out makes `dir` high for exactly one cycle. The word on `din` is then taken and `dir` drops again. That word leaves the buffer after every older word.
- R6: A rising `so` sampled while `dor` is 1 consumes the word on `dout`. From the next cycle `dor` is 0 and `dout` is unchanged. The next word reaches `dout`, and `dor` rises again, only after `so` has been sampled low.
- R7: While `dor` is 0, `dout` keeps the last word it showed.
- R8: If `so` rises while the buffer is completely empty and is then held high, the next word to reach the output stage sets `dor` for exactly one cycle and is consumed. Further words are not delivered until `so` is sampled low.
- R9: A rising `so` while `dor` is 0 and a word is still falling through is ignored. That word is later shown with `dor` 1.
- R10: Words leave in the order they entered, including when `si` and `so` are pulsed one cycle high and one cycle low without regard to the flags.
- R11: A shift-in request made while the buffer is full waits, and it neither overwrites nor drops a stored word. A second rising `si` while one request is still waiting is an overflow and is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| mrst_n | input | 1 | Asynchronous active-low master reset |
| din | input | 9 | Word offered to the input stage |
| si | input | 1 | Shift-in control: rise requests a capture, fall releases the word |
| dir | output | 1 | High when the input stage is empty and can take a word |
| so | input | 1 | Shift-out control: rise consumes, fall allows refill of the output stage |
| dout | output | 9 | Word in the output stage, or the last word shifted out |
| dor | output | 1 | High when `dout` holds a valid unread word |

## Verification
The hardest situation to reach is a write held high against a full buffer (R5). It needs all 64 stages occupied and one shift-out, and then the freed slot has to travel back stage by stage to the input end before the one-cycle `dir` pulse appears. The stimulus fills the buffer, raises `si` and waits, then pulses `so` once. It watches every cycle for the single `dir` pulse and finally drains all 64 words to confirm the order. The held-`so` case (R8) is set up by raising `so` on an empty buffer, writing one word and counting `dor` cycles. A second word is then written to show that it stays blocked until `so` falls.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int unsigned DEF_WIDTH = 9;
  localparam int unsigned DEF_DEPTH = 64;
endpackage

// File: rtl/sfifo_in_ctl.sv
module sfifo_in_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic si,
  input  logic head_busy,
  output logic cap,
  output logic in_blk
);
  logic si_q, pend, hold;
  logic si_rise, req;

  assign si_rise = si & ~si_q;
  assign req     = pend | si_rise;
  assign cap     = req & ~head_busy;
  // word stays at the head while SI remains high after capture
  assign in_blk  = hold & si;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q <= 1'b0;
      pend <= 1'b0;
      hold <= 1'b0;
    end else begin
      si_q <= si;
      pend <= req & ~cap;
      hold <= cap ? si : (hold & si);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    si_rise |-> !pend);

  assert_hold_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_blk && head_busy) |=> head_busy);
endmodule

// File: rtl/sfifo_out_ctl.sv
module sfifo_out_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic so,
  input  logic tail_valid,
  input  logic all_empty,
  output logic consume,
  output logic out_blk
);
  logic so_q, lock, arm;
  logic so_rise;

  assign so_rise = so & ~so_q;
  assign consume = tail_valid & (so_rise | arm);
  assign out_blk = lock & so;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q <= 1'b0;
      lock <= 1'b0;
      arm  <= 1'b0;
    end else begin
      so_q <= so;
      lock <= so & (lock | consume);
      arm  <= so & (arm | (so_rise & all_empty)) & ~consume;
    end
  end

  assert_read_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && so) |-> !consume);
endmodule

// File: rtl/sfifo_stages.sv
module sfifo_stages #(
  parameter int unsigned W = 9,
  parameter int unsigned D = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         cap,
  input  logic         in_blk,
  input  logic         out_blk,
  input  logic         consume,
  output logic [D-1:0] occ,
  output logic [W-1:0] dout
);
  localparam int unsigned LAST = D - 1;

  logic [W-1:0] mem [D];
  logic [D-2:0] mv;

  for (genvar i = 0; i < D - 1; i++) begin : g_mv
    localparam bit IS_HEAD = (i == 0);
    localparam bit IS_TAIL = (i == D - 2);
    assign mv[i] = occ[i] & ~occ[i+1] & ~(IS_HEAD & in_blk) & ~(IS_TAIL & out_blk);
  end

  for (genvar i = 0; i < D; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          occ[i] <= 1'b0;
          mem[i] <= '0;
        end else if (cap) begin
          occ[i] <= 1'b1;
          mem[i] <= din;
        end else if (mv[i]) begin
          occ[i] <= 1'b0;
        end
      end
    end else if (i == LAST) begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          occ[i] <= 1'b0;
          mem[i] <= '0;
        end else if (mv[i-1]) begin
          occ[i] <= 1'b1;
          mem[i] <= mem[i-1];
        end else if (consume) begin
          occ[i] <= 1'b0;
        end
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          occ[i] <= 1'b0;
          mem[i] <= '0;
        end else if (mv[i-1]) begin
          occ[i] <= 1'b1;
          mem[i] <= mem[i-1];
        end else if (mv[i]) begin
          occ[i] <= 1'b0;
        end
      end
    end
  end

  assign dout = mem[LAST];
endmodule

// File: rtl/shift_fifo.sv
module shift_fifo
  import sfifo_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH,
  parameter int unsigned DEPTH = DEF_DEPTH
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic [WIDTH-1:0] din,
  input  logic             si,
  output logic             dir,
  input  logic             so,
  output logic [WIDTH-1:0] dout,
  output logic             dor
);
  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0] occ;
  logic cap, in_blk, consume, out_blk, all_empty;

  assign all_empty = ~|occ;
  assign dir       = ~occ[0];
  assign dor       = occ[LAST];

  sfifo_in_ctl u_in (
    .clk(clk), .rst_n(mrst_n), .si(si), .head_busy(occ[0]),
    .cap(cap), .in_blk(in_blk)
  );

  sfifo_out_ctl u_out (
    .clk(clk), .rst_n(mrst_n), .so(so), .tail_valid(occ[LAST]),
    .all_empty(all_empty), .consume(consume), .out_blk(out_blk)
  );

  sfifo_stages #(.W(WIDTH), .D(DEPTH)) u_stg (
    .clk(clk), .rst_n(mrst_n), .din(din), .cap(cap), .in_blk(in_blk),
    .out_blk(out_blk), .consume(consume), .occ(occ), .dout(dout)
  );

  assert_capture_busy_R2: assert property (@(posedge clk) disable iff (!mrst_n)
    ($rose(si) && dir) |=> !dir);

  assert_consume_drop_R6: assert property (@(posedge clk) disable iff (!mrst_n)
    ($rose(so) && dor) |=> (!dor && $stable(dout)));

  assert_keep_output_R7: assert property (@(posedge clk) disable iff (!mrst_n)
    !dor |=> (dor || $stable(dout)));
endmodule

// File: tb/shift_fifo_tb.sv
module shift_fifo_tb;
  logic       clk = 1'b0;
  logic       mrst_n = 1'b0;
  logic [8:0] din = '0;
  logic       si = 1'b0;
  logic       so = 1'b0;
  logic       dir, dor;
  logic [8:0] dout;

  int nchk = 0;
  int nfail = 0;
  logic [8:0] q[$];

  always #5 clk = ~clk;

  shift_fifo u_dut (
    .clk(clk), .mrst_n(mrst_n), .din(din), .si(si), .dir(dir),
    .so(so), .dout(dout), .dor(dor)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_dir();
    for (int n = 0; n < 400 && !dir; n++) tick();
  endtask

  task automatic wait_dor();
    for (int n = 0; n < 400 && !dor; n++) tick();
  endtask

  task automatic push(input logic [8:0] w, input int hold);
    wait_dir();
    din = w;
    si = 1'b1;
    tick();
    check("R2 dir busy after capture", dir, 0);
    for (int k = 0; k < hold; k++) begin
      tick();
      check("R3 dir low while si held", dir, 0);
    end
    si = 1'b0;
    tick();
    q.push_back(w);
  endtask

  task automatic pop(input string req);
    logic [8:0] w;
    wait_dor();
    w = q.pop_front();
    check({req, " dor before read"}, dor, 1);
    check({req, " read data"}, dout, w);
    so = 1'b1;
    tick();
    check("R6 dor drops on read", dor, 0);
    check("R6 dout kept on read", dout, w);
    so = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    mrst_n = 1'b0;
    repeat (3) tick();
    check("R1 dir after reset", dir, 1);
    check("R1 dor after reset", dor, 0);
    check("R1 dout after reset", dout, 0);
    mrst_n = 1'b1;
    tick();
  endtask

  task automatic t_basic();
    push(9'h0A5, 0);
    push(9'h15A, 4);
    wait_dir();
    check("R4 dir back with space", dir, 1);
    pop("R10");
    pop("R10");
    repeat (10) tick();
    check("R7 dor stays low when empty", dor, 0);
    check("R7 last word kept", dout, 9'h15A);
  endtask

  task automatic t_so_hold();
    push(9'h033, 0);
    push(9'h044, 0);
    wait_dor();
    check("R6 first word", dout, 9'h033);
    so = 1'b1;
    tick();
    check("R6 dor low after consume", dor, 0);
    repeat (5) tick();
    check("R6 no refill while so high", dor, 0);
    check("R6 dout held while so high", dout, 9'h033);
    so = 1'b0;
    void'(q.pop_front());
    wait_dor();
    check("R6 refill after so low", dout, 9'h044);
    pop("R6");
  endtask

  task automatic fill64(input logic [8:0] seed);
    for (int k = 0; k < 64; k++) push(9'((k * 7) + seed), 0);
    repeat (80) tick();
    check("R4 dir low when full", dir, 0);
    check("R4 dor high when full", dor, 1);
  endtask

  task automatic t_held_full();
    int seen;
    fill64(9'h003);
    din = 9'h1C3;
    si = 1'b1;
    repeat (10) tick();
    check("R5 dir low while full", dir, 0);
    pop("R5");
    seen = 0;
    for (int n = 0; n < 200 && !dir; n++) tick();
    check("R5 dir pulse seen", dir, 1);
    tick();
    check("R5 dir low after auto capture", dir, 0);
    q.push_back(9'h1C3);
    repeat (5) tick();
    si = 1'b0;
    tick();
    while (q.size() > 0) pop("R5");
  endtask

  task automatic t_pending_full();
    fill64(9'h010);
    din = 9'h0EE;
    si = 1'b1;
    tick();
    si = 1'b0;
    tick();
    check("R11 dir low with pending request", dir, 0);
    q.push_back(9'h0EE);
    while (q.size() > 0) pop("R11");
  endtask

  task automatic t_held_so_empty();
    int hi;
    so = 1'b1;
    repeat (3) tick();
    push(9'h111, 0);
    hi = 0;
    for (int n = 0; n < 100; n++) begin
      tick();
      if (dor) hi++;
    end
    check("R8 dor pulse count", hi, 1);
    check("R8 auto-read word", dout, 9'h111);
    void'(q.pop_front());
    push(9'h122, 0);
    hi = 0;
    for (int n = 0; n < 100; n++) begin
      tick();
      if (dor) hi++;
    end
    check("R8 blocked until so low", hi, 0);
    check("R8 dout unchanged while blocked", dout, 9'h111);
    so = 1'b0;
    wait_dor();
    check("R8 next word after so low", dout, 9'h122);
    pop("R8");
  endtask

  task automatic t_ignored_so();
    push(9'h099, 0);
    so = 1'b1;
    tick();
    check("R9 dor still low", dor, 0);
    so = 1'b0;
    tick();
    wait_dor();
    check("R9 word not consumed", dor, 1);
    pop("R9");
  endtask

  task automatic t_burst();
    for (int k = 0; k < 20; k++) begin
      din = 9'((k * 13) + 5);
      si = 1'b1;
      tick();
      si = 1'b0;
      tick();
      q.push_back(din);
    end
    repeat (90) tick();
    for (int k = 0; k < 20; k++) begin
      check("R10 burst dor", dor, 1);
      check("R10 burst order", dout, q.pop_front());
      so = 1'b1;
      tick();
      so = 1'b0;
      tick();
    end
    check("R10 empty after burst", dor, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_so_hold();
    t_held_full();
    t_pending_full();
    t_held_so_empty();
    t_ignored_so();
    t_burst();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule